// File: doc/BRIEF.md
# Per-Pin Input Glitch and Debounce Filter Bank

This block conditions the input levels of a bank of general-purpose pins. It sits between the pads and the logic that reads pin data or raises pin interrupts. Every raw pad level first passes through a two-flop synchroniser. Each pin then has its own filter. A disabled filter hands the synchronised level straight on. An enabled filter runs in one of two modes. In glitch mode it accepts a new level only after two consecutive system-clock samples agree. In debounce mode it samples on a strobe from a slow divided clock and accepts a new level only after two consecutive strobes agree.

Software sets up the bank through a single write port. Two write-one registers turn filters on and off, one bit per pin. Two more write-one registers put a pin in debounce mode or back in glitch mode. A divider register holds the shared divide value. The slow clock arrives as a one-cycle strobe (`slow_tick_i`) in the system clock domain. A debounce sample is taken every 2*(DIV+1) slow ticks, and any write to the divider register restarts that count. The per-pin enable and mode bits and the divider value are brought out as status outputs.

Top module: `pin_filter_bank`

## Requirements
- R1: While reset is held, and directly after it, every filtered output, enable bit, mode bit and the divider value are 0, whatever the pad levels are.
- R2: Writing to address 0 sets the enable bit of each pin whose data bit is 1. Writing to address 1 clears it. Data bits that are 0 leave their pins unchanged, and a write to an unused address (5 to 7) changes no state.
- R3: Writing to address 2 puts each pin whose data bit is 1 into debounce mode (mode bit 1). Writing to address 3 puts each such pin back into glitch mode (mode bit 0). Data bits that are 0 have no effect.
- R4: Writing to address 4 loads the divider with the low DIV_W bits of the write data (14 bits by default). Higher bits are masked off.
- R5: A pin whose filter is disabled drives its output with the pad level after three rising clock edges (two for the synchroniser, one for the output register), and no filtering is applied.
- R6: In glitch mode, a pad pulse that lasts one clock cycle never reaches the output. A level held for two cycles appears at the output after the fourth rising edge, counted from the edge that first samples it.
- R7: In debounce mode, the output changes only on a sample strobe. One strobe comes on every 2*(DIV+1)-th slow tick after the last divider write. A new level is accepted only when two consecutive strobes see it, so a short excursion between strobes is rejected.
- R8: A write to the divider register restarts the slow-tick count, so that the next strobe comes 2*(DIV+1) ticks after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Write address: 0 enable set, 1 enable clear, 2 debounce set, 3 glitch select, 4 divider |
| wr_data_i | input | NPINS | Write data, one bit per pin, or the divider value in the low bits |
| slow_tick_i | input | 1 | One-cycle strobe for each slow-clock period |
| pad_i | input | NPINS | Raw asynchronous pad levels |
| pin_o | output | NPINS | Filtered pin levels |
| flt_en_o | output | NPINS | Per-pin filter enable status |
| flt_deb_o | output | NPINS | Per-pin mode status, 1 for debounce |
| div_o | output | DIV_W | Current divider value |

## Verification
The hardest case to reach from the ports is the divider restart. It only shows when a strobe would have fallen inside a window that a divider write has cut short, and when that strobe would also have been the second agreeing sample that changes the output. The stimulus first lets one strobe record a new pad level. It then gives three ticks, rewrites the divider, and gives three more ticks. The output must still hold the old level, because without the restart the fourth tick would have completed the change. One further tick then produces the strobe that the restarted count predicts, and the output must change on it.

// File: rtl/pinflt_pkg.sv
package pinflt_pkg;

  localparam int unsigned CFG_ADDR_W = 3;

  // Write-port address map; addresses 5..7 are unused and ignored.
  typedef enum logic [CFG_ADDR_W-1:0] {
    CFG_EN_SET  = 3'd0,
    CFG_EN_CLR  = 3'd1,
    CFG_DEB_SET = 3'd2,
    CFG_DEB_CLR = 3'd3,
    CFG_DIV     = 3'd4
  } cfg_addr_e;

endpackage

// File: rtl/pinflt_sync.sv
module pinflt_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = async_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/pinflt_cfg.sv
module pinflt_cfg
  import pinflt_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DIV_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CFG_ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]      wr_data_i,
  output logic [NPINS-1:0]      en_o,
  output logic [NPINS-1:0]      deb_o,
  output logic [DIV_W-1:0]      div_o,
  output logic                  div_wr_o
);

  logic [NPINS-1:0] en_q, en_d;
  logic [NPINS-1:0] deb_q, deb_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_wr;

  always_comb begin
    en_d   = en_q;
    deb_d  = deb_q;
    div_d  = div_q;
    div_wr = 1'b0;
    if (wr_en_i) begin
      case (wr_addr_i)
        CFG_EN_SET:  en_d  = en_q | wr_data_i;
        CFG_EN_CLR:  en_d  = en_q & ~wr_data_i;
        CFG_DEB_SET: deb_d = deb_q | wr_data_i;
        CFG_DEB_CLR: deb_d = deb_q & ~wr_data_i;
        CFG_DIV: begin
          div_d  = wr_data_i[DIV_W-1:0];
          div_wr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      deb_q <= '0;
      div_q <= '0;
    end else begin
      en_q  <= en_d;
      deb_q <= deb_d;
      div_q <= div_d;
    end
  end

  assign en_o     = en_q;
  assign deb_o    = deb_q;
  assign div_o    = div_q;
  assign div_wr_o = div_wr;

  AST_EN_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CFG_EN_SET) |=> ((en_q & $past(wr_data_i)) == $past(wr_data_i))); // R2
  AST_EN_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CFG_EN_CLR) |=> ((en_q & $past(wr_data_i)) == '0)); // R2
  AST_EN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (wr_addr_i == CFG_EN_SET || wr_addr_i == CFG_EN_CLR)) |=> $stable(en_q)); // R2
  AST_DEB_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CFG_DEB_SET) |=> ((deb_q & $past(wr_data_i)) == $past(wr_data_i))); // R3
  AST_DEB_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CFG_DEB_CLR) |=> ((deb_q & $past(wr_data_i)) == '0)); // R3
  AST_DIV_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == CFG_DIV) |=> $stable(div_q)); // R4

endmodule

// File: rtl/pinflt_div.sv
module pinflt_div #(
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             samp_o
);

  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             wrap;

  // Period is 2*(DIV+1) ticks, so the terminal count is 2*DIV+1.
  assign last = {div_i, 1'b1};
  assign wrap = tick_i && !restart_i && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == last) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign samp_o = wrap;

  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R8
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= {div_i, 1'b1}); // R7
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/pinflt_cell.sv
module pinflt_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic en_i,
  input  logic deb_i,
  input  logic samp_i,
  output logic out_o
);

  logic gprev_q, gprev_d;
  logic dprev_q, dprev_d;
  logic out_q, out_d;

  always_comb begin
    gprev_d = sync_i;
    dprev_d = samp_i ? sync_i : dprev_q;
    out_d   = out_q;
    if (!en_i) begin
      out_d = sync_i;
    end else if (!deb_i) begin
      if (sync_i == gprev_q) out_d = sync_i;
    end else if (samp_i && (sync_i == dprev_q)) begin
      out_d = sync_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gprev_q <= 1'b0;
      dprev_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      gprev_q <= gprev_d;
      dprev_q <= dprev_d;
      out_q   <= out_d;
    end
  end

  assign out_o = out_q;

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (out_q == $past(sync_i))); // R5
  AST_GLITCH_NEEDS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !deb_i && (sync_i != gprev_q)) |=> $stable(out_q)); // R6
  AST_DEB_ONLY_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && deb_i && !samp_i) |=> $stable(out_q)); // R7
  AST_DEB_NEEDS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && deb_i && (sync_i != dprev_q)) |=> $stable(out_q)); // R7

endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank
  import pinflt_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DIV_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CFG_ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]      wr_data_i,
  input  logic                  slow_tick_i,
  input  logic [NPINS-1:0]      pad_i,
  output logic [NPINS-1:0]      pin_o,
  output logic [NPINS-1:0]      flt_en_o,
  output logic [NPINS-1:0]      flt_deb_o,
  output logic [DIV_W-1:0]      div_o
);

  localparam int unsigned RST_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_pipe_q[RST_STAGES-1];

  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] en;
  logic [NPINS-1:0] deb;
  logic [DIV_W-1:0] div_val;
  logic             div_wr;
  logic             samp;

  pinflt_sync #(.WIDTH(NPINS)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (pad_i),
    .sync_o  (pad_sync)
  );

  pinflt_cfg #(.NPINS(NPINS), .DIV_W(DIV_W)) cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_o      (en),
    .deb_o     (deb),
    .div_o     (div_val),
    .div_wr_o  (div_wr)
  );

  pinflt_div #(.DIV_W(DIV_W)) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (slow_tick_i),
    .div_i     (div_val),
    .restart_i (div_wr),
    .samp_o    (samp)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pinflt_cell cell_i (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .sync_i (pad_sync[p]),
      .en_i   (en[p]),
      .deb_i  (deb[p]),
      .samp_i (samp),
      .out_o  (pin_o[p])
    );
  end

  assign flt_en_o  = en;
  assign flt_deb_o = deb;
  assign div_o     = div_val;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n |=> (pin_o == '0 || !rst_n)); // R1

endmodule

// File: tb/pin_filter_bank_tb_top.sv
module pin_filter_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 32;
  localparam int DIV_W      = 14;
  localparam int NVEC       = 11;
  localparam int VEC_W      = 3 + 32 + 32 + 32 + 14;

  // {addr, data, expected enables, expected modes, expected divider}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {3'd0, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000, 14'h0000},
    {3'd0, 32'h0000_0F00, 32'h0000_0FF0, 32'h0000_0000, 14'h0000},
    {3'd1, 32'h0000_0030, 32'h0000_0FC0, 32'h0000_0000, 14'h0000},
    {3'd0, 32'h0000_0000, 32'h0000_0FC0, 32'h0000_0000, 14'h0000},
    {3'd2, 32'h8000_0101, 32'h0000_0FC0, 32'h8000_0101, 14'h0000},
    {3'd3, 32'h0000_0100, 32'h0000_0FC0, 32'h8000_0001, 14'h0000},
    {3'd4, 32'hFFFF_FFFF, 32'h0000_0FC0, 32'h8000_0001, 14'h3FFF},
    {3'd4, 32'h0000_0005, 32'h0000_0FC0, 32'h8000_0001, 14'h0005},
    {3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 14'h0005},
    {3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 14'h0005},
    {3'd5, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 14'h0005}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             wr_en_i;
  logic [2:0]       wr_addr_i;
  logic [NPINS-1:0] wr_data_i;
  logic             slow_tick_i;
  logic [NPINS-1:0] pad_i;
  logic [NPINS-1:0] pin_o;
  logic [NPINS-1:0] flt_en_o;
  logic [NPINS-1:0] flt_deb_o;
  logic [DIV_W-1:0] div_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pin_filter_bank #(.NPINS(NPINS), .DIV_W(DIV_W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .slow_tick_i (slow_tick_i),
    .pad_i       (pad_i),
    .pin_o       (pin_o),
    .flt_en_o    (flt_en_o),
    .flt_deb_o   (flt_deb_o),
    .div_o       (div_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [NPINS-1:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = a;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      slow_tick_i = 1'b1;
      @(negedge clk_i);
      slow_tick_i = 1'b0;
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    report();
  end

  initial begin
    rst_ni      = 1'b0;
    wr_en_i     = 1'b0;
    wr_addr_i   = '0;
    wr_data_i   = '0;
    slow_tick_i = 1'b0;
    pad_i       = '1;
    step(4);
    // R1: quiet during reset even with every pad high
    check("R1", "pin_o in reset", 64'(pin_o), 64'h0);
    check("R1", "enables in reset", 64'(flt_en_o), 64'h0);
    pad_i  = '0;
    rst_ni = 1'b1;
    step(5);
    check("R1", "pin_o after reset", 64'(pin_o), 64'h0);
    check("R1", "modes after reset", 64'(flt_deb_o), 64'h0);
    check("R1", "divider after reset", 64'(div_o), 64'h0);

    // Register vectors: R2 enables, R3 modes, R4 divider masking
    for (int v = 0; v < NVEC; v++) begin
      logic [VEC_W-1:0] e;
      e = VECS[v];
      cfg_write(e[112:110], e[109:78]);
      check("R2", "enable status", 64'(flt_en_o), 64'(e[77:46]));
      check("R3", "mode status", 64'(flt_deb_o), 64'(e[45:14]));
      check("R4", "divider value", 64'(div_o), 64'(e[13:0]));
    end

    // R5: disabled pin follows pad after three edges
    pad_i[0] = 1'b1;
    step(2);
    check("R5", "bypass before third edge", 64'(pin_o[0]), 64'h0);
    step(1);
    check("R5", "bypass after third edge", 64'(pin_o[0]), 64'h1);
    pad_i[0] = 1'b0;
    step(4);

    // R6: glitch mode on pin 1
    cfg_write(3'd0, 32'h0000_0002);
    step(4);
    pad_i[1] = 1'b1;
    step(1);
    pad_i[1] = 1'b0;
    step(6);
    check("R6", "one-cycle pulse rejected", 64'(pin_o[1]), 64'h0);
    pad_i[1] = 1'b1;
    step(2);
    pad_i[1] = 1'b0;
    step(1);
    check("R6", "two-cycle pulse before fourth edge", 64'(pin_o[1]), 64'h0);
    step(1);
    check("R6", "two-cycle pulse after fourth edge", 64'(pin_o[1]), 64'h1);
    step(2);
    check("R6", "output returns low", 64'(pin_o[1]), 64'h0);

    // R7: debounce mode on pin 2, DIV=1 -> strobe every 4 ticks
    cfg_write(3'd4, 32'h0000_0001);
    cfg_write(3'd2, 32'h0000_0004);
    cfg_write(3'd0, 32'h0000_0004);
    pad_i[2] = 1'b1;
    step(4);
    check("R7", "no change without strobe", 64'(pin_o[2]), 64'h0);
    tick(4);
    check("R7", "one strobe is not enough", 64'(pin_o[2]), 64'h0);
    tick(3);
    check("R7", "no change before 4th tick", 64'(pin_o[2]), 64'h0);
    tick(1);
    check("R7", "accepted on second strobe", 64'(pin_o[2]), 64'h1);
    tick(2);
    pad_i[2] = 1'b0;
    step(3);
    pad_i[2] = 1'b1;
    step(4);
    tick(2);
    check("R7", "short dip between strobes rejected", 64'(pin_o[2]), 64'h1);

    // R8: divider write restarts the count
    pad_i[2] = 1'b0;
    step(4);
    tick(4);
    check("R8", "first low strobe holds output", 64'(pin_o[2]), 64'h1);
    tick(3);
    cfg_write(3'd4, 32'h0000_0001);
    tick(3);
    check("R8", "no strobe after restart", 64'(pin_o[2]), 64'h1);
    tick(1);
    check("R8", "strobe on 4th tick after restart", 64'(pin_o[2]), 64'h0);

    // R5: disabling a debounced pin returns it to bypass
    cfg_write(3'd1, 32'h0000_0004);
    pad_i[2] = 1'b1;
    step(3);
    check("R5", "disabled pin bypasses filter", 64'(pin_o[2]), 64'h1);

    report();
  end

endmodule